// File: doc/BRIEF.md
# Two-Wire Register Slave

This block is a serial slave on an open-drain two-wire bus (I2C-style) that lets a host read and write a bank of 64 byte-wide control registers. It oversamples the clock and data lines with the system clock, detects start and stop conditions, and answers only to its own device-select byte. A two-byte word address follows the device-select byte. After that the host can write one byte or a run of bytes, read from the current pointer, or do a random read. A random read is a write phase that carries only the address, then a repeated start with the read flag set.

The top register is a volatile status byte that holds two write-enable latches. Every other register changes only while both latches are set. Writes that the latches block are still acknowledged, so the host sees no difference on the bus. Each accepted write is announced to the rest of the device by a one-cycle strobe that carries the register address and data. The block never drives the data line high. It only pulls it low, and a change to that pull-down happens only while the bus clock is low.

Top module: `tws_regslave`

## Requirements
- R1: The slave acknowledges a device-select byte whose upper seven bits are 1101111 (0xDE to write, 0xDF to read; bit 0 is the read flag). Any other byte is not acknowledged, and the slave ignores the bus until the next start condition.
- R2: The word address is two bytes, high byte first. Both are acknowledged when the 16-bit address is 0x0000 to 0x003F. For any larger address the low byte is not acknowledged and the transfer is ignored until the next start.
- R3: Each data byte of a write is acknowledged, and the pointer then moves on by one. It wraps from 0x3F to 0x00, so a run of writes stays inside the single 64-byte page.
- R4: The status register is at 0x3F. Bit 0 is the first enable latch and bit 1 is the second; bits 7..2 read 0. Writes to it are always accepted. The first latch takes the written bit 0. The second latch is set only if the written bit 1 is 1 and the first latch was already 1 before that write.
- R5: A write to addresses 0x00 to 0x3E takes effect only when both latches are 1. Otherwise the byte is discarded but still acknowledged.
- R6: A read that starts right after device selection returns the byte at the current pointer. The pointer moves on by one after every byte and wraps from 0x3F to 0x00.
- R7: A random read (address write, then a repeated start with the read flag set) returns the register at the written address.
- R8: A read goes on while the host acknowledges each byte. After a host NACK the slave releases the data line and stays silent until the next start.
- R9: The data-line pull-down turns on only while the bus clock is low, and it is off after a stop condition.
- R10: After reset all registers and both latches are 0, the data line is released and there is no strobe.
- R11: Each accepted write gives exactly one strobe cycle, with the register address and data, after the eighth bit of that data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_pull_lo | output | 1 | 1 pulls the data line low |
| wr_stb | output | 1 | One-cycle pulse for each accepted register write |
| wr_addr | output | 6 | Register address of the accepted write |
| wr_data | output | 8 | Data of the accepted write |

## Verification
Two functions meet when a page write runs through the status register and wraps to address 0x00. The byte for 0x3F updates the enable latches on the same edge that commits and strobes it, and the next byte is gated by the new latch values. The bench sends a page write whose status byte clears the first latch, followed by a byte for 0x00. It checks that no strobe appears for the second byte and that a later read of 0x00 returns the old value. A second page write with the latches left set checks that the same wrap does commit.

// File: rtl/tws_pkg.sv
package tws_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_DEV,
      ST_ADRH,
      ST_ADRL,
      ST_WDAT,
      ST_ACK,
      ST_RDAT,
      ST_MACK,
      ST_SKIP
   } tws_state_e;

   localparam int BYTE_W = 8;

endpackage

// File: rtl/tws_sync.sv
module tws_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   generate
      if (STAGES == 0) begin : g_direct
         assign scl_s = scl_in;
         assign sda_s = sda_in;
      end else begin : g_chain
         logic [STAGES-1:0] scl_c;
         logic [STAGES-1:0] sda_c;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_c <= '1;
               sda_c <= '1;
            end else begin
               scl_c[0] <= scl_in;
               sda_c[0] <= sda_in;
               for (int i = 1; i < STAGES; i++) begin
                  scl_c[i] <= scl_c[i-1];
                  sda_c[i] <= sda_c[i-1];
               end
            end
         end
         assign scl_s = scl_c[STAGES-1];
         assign sda_s = sda_c[STAGES-1];
      end
   endgenerate

   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/tws_regfile.sv
module tws_regfile #(
   parameter int ADDR_W   = 6,
   parameter int WEL_BIT  = 0,
   parameter int RWEL_BIT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [7:0]        req_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        rd_data,
   output logic              wel,
   output logic              rwel,
   output logic              wr_stb,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [7:0]        wr_data
);

   localparam int DEPTH = 1 << ADDR_W;
   localparam logic [ADDR_W-1:0] STAT = '1;

   logic             is_stat;
   logic             accept;
   logic [7:0]       stat_byte;
   logic [DEPTH*8-1:0] flat;

   assign is_stat = (req_addr == STAT);
   assign accept  = req & (is_stat | (wel & rwel));

   always_comb begin
      stat_byte           = '0;
      stat_byte[WEL_BIT]  = wel;
      stat_byte[RWEL_BIT] = rwel;
   end

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_ent
         if (g == DEPTH - 1) begin : g_stat
            assign flat[g*8 +: 8] = stat_byte;
         end else begin : g_data
            logic [7:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)
                  q <= '0;
               else if (accept && req_addr == ADDR_W'(g))
                  q <= req_data;
            end
            assign flat[g*8 +: 8] = q;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wel  <= 1'b0;
         rwel <= 1'b0;
      end else if (accept && is_stat) begin
         wel  <= req_data[WEL_BIT];
         rwel <= req_data[RWEL_BIT] & wel;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_stb  <= 1'b0;
         wr_addr <= '0;
         wr_data <= '0;
      end else begin
         wr_stb <= accept;
         if (accept) begin
            wr_addr <= req_addr;
            wr_data <= req_data;
         end
      end
   end

   assign rd_data = flat[rd_addr*8 +: 8];

endmodule

// File: rtl/tws_ctrl.sv
module tws_ctrl
   import tws_pkg::*;
#(
   parameter int          ADDR_W = 6,
   parameter logic [6:0]  DEV_ID = 7'b1101111
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sda_s,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic [7:0]        rd_data,
   output logic [ADDR_W-1:0] ptr,
   output logic              req,
   output logic [ADDR_W-1:0] req_addr,
   output logic [7:0]        req_data,
   output logic              pull_lo
);

   localparam logic [15:0] TOP_ADDR = 16'((1 << ADDR_W) - 1);

   tws_state_e state, nxt;
   logic [7:0] sh;
   logic [7:0] ahi;
   logic [3:0] cnt;
   logic       got8;

   assign got8 = (cnt == 4'd8);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         nxt      <= ST_IDLE;
         sh       <= '0;
         ahi      <= '0;
         cnt      <= '0;
         ptr      <= '0;
         req      <= 1'b0;
         req_addr <= '0;
         req_data <= '0;
         pull_lo  <= 1'b0;
      end else begin
         req <= 1'b0;
         if (start_det) begin
            state   <= ST_DEV;
            cnt     <= '0;
            pull_lo <= 1'b0;
         end else if (stop_det) begin
            state   <= ST_IDLE;
            pull_lo <= 1'b0;
         end else if (scl_rise) begin
            case (state)
               ST_DEV, ST_ADRH, ST_ADRL, ST_WDAT: begin
                  if (!got8) begin
                     sh  <= {sh[6:0], sda_s};
                     cnt <= cnt + 4'd1;
                  end
               end
               ST_MACK: if (sda_s) state <= ST_SKIP;
               default: ;
            endcase
         end else if (scl_fall) begin
            case (state)
               ST_DEV: if (got8) begin
                  if (sh[7:1] == DEV_ID) begin
                     nxt     <= sh[0] ? ST_RDAT : ST_ADRH;
                     state   <= ST_ACK;
                     pull_lo <= 1'b1;
                  end else begin
                     state <= ST_SKIP;
                  end
               end
               ST_ADRH: if (got8) begin
                  ahi     <= sh;
                  nxt     <= ST_ADRL;
                  state   <= ST_ACK;
                  pull_lo <= 1'b1;
               end
               ST_ADRL: if (got8) begin
                  if ({ahi, sh} <= TOP_ADDR) begin
                     ptr     <= sh[ADDR_W-1:0];
                     nxt     <= ST_WDAT;
                     state   <= ST_ACK;
                     pull_lo <= 1'b1;
                  end else begin
                     state <= ST_SKIP;
                  end
               end
               ST_WDAT: if (got8) begin
                  req      <= 1'b1;
                  req_addr <= ptr;
                  req_data <= sh;
                  ptr      <= ptr + 1'b1;
                  nxt      <= ST_WDAT;
                  state    <= ST_ACK;
                  pull_lo  <= 1'b1;
               end
               ST_ACK: begin
                  state <= nxt;
                  if (nxt == ST_RDAT) begin
                     pull_lo <= ~rd_data[7];
                     sh      <= {rd_data[6:0], 1'b0};
                     cnt     <= 4'd1;
                  end else begin
                     pull_lo <= 1'b0;
                     cnt     <= '0;
                  end
               end
               ST_RDAT: begin
                  if (!got8) begin
                     pull_lo <= ~sh[7];
                     sh      <= {sh[6:0], 1'b0};
                     cnt     <= cnt + 4'd1;
                  end else begin
                     pull_lo <= 1'b0;
                     ptr     <= ptr + 1'b1;
                     state   <= ST_MACK;
                  end
               end
               ST_MACK: begin
                  pull_lo <= ~rd_data[7];
                  sh      <= {rd_data[6:0], 1'b0};
                  cnt     <= 4'd1;
                  state   <= ST_RDAT;
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/tws_regslave.sv
module tws_regslave #(
   parameter int          ADDR_W      = 6,
   parameter logic [6:0]  DEV_ID      = 7'b1101111,
   parameter int          SYNC_STAGES = 2,
   parameter int          WEL_BIT     = 0,
   parameter int          RWEL_BIT    = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_in,
   input  logic              sda_in,
   output logic              sda_pull_lo,
   output logic              wr_stb,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [7:0]        wr_data
);

   generate
      if (ADDR_W < 1 || ADDR_W > 8) begin : g_bad_aw
         $error("tws_regslave: ADDR_W must lie in 1..8");
      end
      if (WEL_BIT == RWEL_BIT || WEL_BIT > 7 || RWEL_BIT > 7) begin : g_bad_bits
         $error("tws_regslave: latch bits must differ and lie in 0..7");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("tws_regslave: SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic [ADDR_W-1:0] ptr, req_addr;
   logic [7:0]        req_data, rd_data;
   logic              req, wel, rwel;

   tws_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_in    (scl_in),
      .sda_in    (sda_in),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   tws_ctrl #(.ADDR_W(ADDR_W), .DEV_ID(DEV_ID)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .rd_data   (rd_data),
      .ptr       (ptr),
      .req       (req),
      .req_addr  (req_addr),
      .req_data  (req_data),
      .pull_lo   (sda_pull_lo)
   );

   tws_regfile #(.ADDR_W(ADDR_W), .WEL_BIT(WEL_BIT), .RWEL_BIT(RWEL_BIT)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (req),
      .req_addr (req_addr),
      .req_data (req_data),
      .rd_addr  (ptr),
      .rd_data  (rd_data),
      .wel      (wel),
      .rwel     (rwel),
      .wr_stb   (wr_stb),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data)
   );

endmodule

// File: rtl/tws_regslave_chk.sv
module tws_regslave_chk #(
   parameter int ADDR_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              scl_s,
   input logic              stop_det,
   input logic              sda_pull_lo,
   input logic              wr_stb,
   input logic [ADDR_W-1:0] wr_addr,
   input logic              wel,
   input logic              rwel
);

   localparam logic [ADDR_W-1:0] STAT = '1;

   AST_PULL_ON_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_pull_lo) |-> !scl_s);  // R9

   AST_RELEASE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_pull_lo);  // R9

   AST_STB_NEEDS_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && wr_addr != STAT) |-> $past(wel && rwel));  // R5

   AST_RWEL_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rwel) |-> $past(wel));  // R4

   AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> !wr_stb);  // R11

endmodule

bind tws_regslave tws_regslave_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .scl_s       (scl_s),
   .stop_det    (stop_det),
   .sda_pull_lo (sda_pull_lo),
   .wr_stb      (wr_stb),
   .wr_addr     (wr_addr),
   .wel         (wel),
   .rwel        (rwel)
);

// File: tb/tws_regslave_bench.sv
module tws_regslave_bench;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic scl = 1'b1;
   logic m_sda = 1'b1;
   logic pull;
   logic wr_stb;
   logic [5:0] wr_addr;
   logic [7:0] wr_data;
   wire sda_line = m_sda & ~pull;

   tws_regslave u_tws_regslave (
      .clk         (clk),
      .rst_n       (rst_n),
      .scl_in      (scl),
      .sda_in      (sda_line),
      .sda_pull_lo (pull),
      .wr_stb      (wr_stb),
      .wr_addr     (wr_addr),
      .wr_data     (wr_data)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   logic [7:0]  mreg [64];
   logic        mwel = 0, mrwel = 0;
   int          mptr = 0;
   logic [13:0] expq[$];
   logic [7:0]  pay[$];
   logic        prev_pull = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // per-clock comparison of strobe and pull-down against the model
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (wr_stb) begin
            if (expq.size() == 0) chk(0, "R5", {26'd0, wr_addr}, 0);
            else begin
               logic [13:0] e;
               e = expq.pop_front();
               chk({wr_addr, wr_data} == e, "R11", {18'd0, wr_addr, wr_data}, {18'd0, e});
            end
         end
         if (pull && !prev_pull && scl) chk(0, "R9", 1, 0);
         prev_pull = pull;
      end
   end

   task automatic w(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      m_sda = 1; w(8); scl = 1; w(8); m_sda = 0; w(8); scl = 0;
   endtask

   task automatic bus_stop();
      m_sda = 0; w(8); scl = 1; w(8); m_sda = 1; w(8);
   endtask

   task automatic send_bit(input logic b);
      m_sda = b; w(8); scl = 1; w(8); scl = 0;
   endtask

   task automatic get_bit(output logic v);
      m_sda = 1; w(8); scl = 1; w(4); v = sda_line; w(4); scl = 0;
   endtask

   task automatic wbyte(input logic [7:0] b, input bit exp_ack, input string req);
      logic a;
      for (int i = 7; i >= 0; i--) send_bit(b[i]);
      get_bit(a);
      chk(a == !exp_ack, req, a, !exp_ack);
   endtask

   task automatic rbyte(output logic [7:0] b, input bit host_ack);
      for (int i = 7; i >= 0; i--) get_bit(b[i]);
      send_bit(!host_ack);
   endtask

   function automatic logic [7:0] mval(input int a);
      return (a == 63) ? {6'd0, mrwel, mwel} : mreg[a];
   endfunction

   task automatic mwrite(input int a, input logic [7:0] d);
      if (a == 63) begin
         expq.push_back({6'(a), d});
         mrwel = d[1] & mwel;
         mwel  = d[0];
      end else if (mwel && mrwel) begin
         expq.push_back({6'(a), d});
         mreg[a] = d;
      end
   endtask

   task automatic wr_txn(input int addr, input string req);
      bit ok;
      ok = (addr < 64);
      bus_start();
      wbyte(8'hDE, 1, "R1");
      wbyte(8'(addr >> 8), 1, "R2");
      wbyte(8'(addr), ok, "R2");
      if (ok) begin
         mptr = addr;
         foreach (pay[i]) begin
            mwrite(mptr, pay[i]);
            mptr = (mptr + 1) % 64;
            wbyte(pay[i], 1, req);
         end
      end
      bus_stop();
      w(8);
      chk(expq.size() == 0, req, expq.size(), 0);
   endtask

   task automatic rd_cur(input int n, input string req);
      logic [7:0] b;
      bus_start();
      wbyte(8'hDF, 1, "R1");
      for (int i = 0; i < n; i++) begin
         rbyte(b, i != n - 1);
         chk(b == mval(mptr), req, b, mval(mptr));
         mptr = (mptr + 1) % 64;
      end
      w(16);
      chk(pull == 0, "R8", pull, 0);
      bus_stop();
      w(4);
      chk(pull == 0, "R9", pull, 0);
   endtask

   task automatic rd_rand(input int addr, input int n, input string req);
      bus_start();
      wbyte(8'hDE, 1, "R1");
      wbyte(8'(addr >> 8), 1, "R2");
      wbyte(8'(addr), 1, "R2");
      mptr = addr;
      rd_cur(n, req);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
         finished = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 64; i++) mreg[i] = 8'h00;
      w(5);
      chk(pull == 0, "R10", pull, 0);
      chk(wr_stb == 0, "R10", wr_stb, 0);
      rst_n = 1;
      w(10);

      // R10 reset contents, R4 status reads 0
      rd_rand(16, 2, "R10");
      rd_rand(63, 1, "R4");

      // R5 protected write: acked, discarded
      pay.delete(); pay.push_back(8'hAA);
      wr_txn(5, "R5");
      rd_rand(5, 1, "R5");

      // R4 second latch without the first stays clear
      pay.delete(); pay.push_back(8'h02);
      wr_txn(63, "R4");
      rd_rand(63, 1, "R4");
      pay.delete(); pay.push_back(8'h01);
      wr_txn(63, "R4");
      pay.delete(); pay.push_back(8'h03);
      wr_txn(63, "R4");
      rd_rand(63, 1, "R4");

      // R3 byte write, R7 random read back
      pay.delete(); pay.push_back(8'hA5);
      wr_txn(5, "R3");
      rd_rand(5, 1, "R7");

      // status write inside a page write closes the gate for the wrapped byte
      pay.delete(); pay.push_back(8'h11); pay.push_back(8'h22); pay.push_back(8'h33);
      wr_txn(62, "R5");
      rd_rand(0, 1, "R5");
      rd_rand(63, 1, "R4");

      // re-open, then page write with wrap that commits
      pay.delete(); pay.push_back(8'h01);
      wr_txn(63, "R4");
      pay.delete(); pay.push_back(8'h03);
      wr_txn(63, "R4");
      pay.delete();
      pay.push_back(8'h61); pay.push_back(8'h62); pay.push_back(8'h03);
      pay.push_back(8'hC0); pay.push_back(8'hC1); pay.push_back(8'hC2);
      pay.push_back(8'hC3);
      wr_txn(61, "R3");

      // R6 current-address reads continue from the pointer
      rd_cur(2, "R6");
      rd_cur(1, "R6");
      rd_rand(61, 4, "R6");

      // R1 wrong device select is ignored
      bus_start();
      wbyte(8'hA0, 0, "R1");
      wbyte(8'h00, 0, "R1");
      wbyte(8'h05, 0, "R1");
      bus_stop();
      w(8);
      chk(pull == 0, "R1", pull, 0);
      rd_rand(5, 1, "R1");

      // R2 out-of-range addresses
      pay.delete(); pay.push_back(8'h77);
      wr_txn(64, "R2");
      wr_txn(256, "R2");
      rd_rand(0, 1, "R2");

      w(20);
      chk(expq.size() == 0, "R11", expq.size(), 0);
      if (!finished) begin
         finished = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule